// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a synchronous host and an asynchronous byte-wide static RAM of 128K words. The RAM has four control pins: a select that is active low, an enable that is active high, a write strobe that is active low and an output gate that is active low. The host gives a one-cycle request strobe together with a write flag, an address and write data. The sequencer then moves the RAM pins through the phases of a read or a write. It ends each access with a one-cycle `done` pulse. For a read, the captured byte is valid on `rdata` during that pulse.

The length of each phase is a count of system clock cycles. Every count is worked out at elaboration time from the clock period and the RAM's minimum times in nanoseconds, rounded up, and no phase is shorter than one cycle. The sequencer drives the data bus out only when a write pulse is active. It waits out the RAM's output turn-off time after any read before it drives. Between accesses it holds the RAM deselected, which is its low-power state.

Top module: `sram_ctl`

## Requirements
- R1: During reset and until the first request, the pins idle: select high, enable low, write strobe high, output gate high, `mem_dq_oe` low, and `done` low.
- R2: A read holds select low, enable high, write strobe high and output gate low for exactly RD_CYC consecutive cycles, with `mem_addr` equal to the requested address. RD_CYC is the larger of ceil(T_AA_NS/CLK_PERIOD_NS) and ceil(T_OE_NS/CLK_PERIOD_NS), and at least 1.
- R3: A read's byte is taken from `mem_dq_in` in the last read cycle. It appears on `rdata` together with a one-cycle `done` that is high RD_CYC+1 cycles after the accepting clock edge's cycle.
- R4: A write holds the write strobe low for exactly PULSE_CYC consecutive cycles. Throughout that time select is low, enable is high, the output gate is high, and `mem_addr` stays stable at the requested address. PULSE_CYC is the larger of ceil(T_WP_NS/period) and ceil(T_DW_NS/period).
- R5: `mem_dq_oe` is high, with `mem_dq_out` equal to the write data, in every write-strobe-low cycle. It is low from the cycle in which the write strobe returns high.
- R6: After each write pulse, the write strobe stays high for at least REC_CYC cycles before any later write pulse. REC_CYC is the larger of ceil(T_WR_NS/period) and ceil(T_WC_NS/period)−PULSE_CYC. A write's `done` comes PULSE_CYC+REC_CYC+1 cycles after acceptance, plus HZ_CYC when R7 applies.
- R7: A write that follows a read first spends HZ_CYC = ceil(T_HZ_NS/period) deselected cycles, so that at least HZ_CYC cycles with the output gate high come before `mem_dq_oe` rises. `mem_dq_oe` is never high while the output gate is low.
- R8: A request that arrives while an access is in progress is ignored: it produces no `done` and no RAM write.
- R9: Back-to-back accesses are accepted in the cycle in which the previous `done` is high. Consecutive writes each get their own write-strobe pulse.
- R10: In the cycle in which `done` is high, the pins are back in the idle, deselected state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req | input | 1 | One-cycle access request, sampled only when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid with `done` after a read |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | ADDR_W | RAM address bus |
| mem_ncs | output | 1 | RAM select, active low |
| mem_ce | output | 1 | RAM enable, active high |
| mem_nwe | output | 1 | RAM write strobe, active low |
| mem_noe | output | 1 | RAM output gate, active low |
| mem_dq_out | output | DATA_W | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | DATA_W | Data returned from the RAM |

## Verification
The bench builds the block with an 8 ns period and the default RAM times, but raises T_WC_NS to 40. That gives RD_CYC=4, PULSE_CYC=3, HZ_CYC=2, and a recovery of 2 cycles that comes from the cycle-time term, not the recovery-time term. So the branch that stretches recovery to meet the total write cycle is exercised. At these values the turnaround after a read is longer than the single idle cycle the sequencer passes through anyway. A design that skipped the turnaround would therefore drive the bus too early, and the bench would see it. The values also make read, write and write-after-read latencies differ from one another, so each path's cycle count is checked on its own.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_TURN   = 3'd2,
    ST_WPULSE = 3'd3,
    ST_WREC   = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic ncs;
    logic ce;
    logic nwe;
    logic noe;
    logic dq_oe;
  } ram_pins_t;

  // nanoseconds to whole cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // pin levels belonging to each phase
  function automatic ram_pins_t pins_of(input seq_state_e s);
    ram_pins_t p;
    p = '{ncs: 1'b1, ce: 1'b0, nwe: 1'b1, noe: 1'b1, dq_oe: 1'b0};
    case (s)
      ST_READ:   p = '{ncs: 1'b0, ce: 1'b1, nwe: 1'b1, noe: 1'b0, dq_oe: 1'b0};
      ST_WPULSE: p = '{ncs: 1'b0, ce: 1'b1, nwe: 1'b0, noe: 1'b1, dq_oe: 1'b1};
      ST_WREC:   p = '{ncs: 1'b0, ce: 1'b1, nwe: 1'b1, noe: 1'b1, dq_oe: 1'b0};
      default:   ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                cnt_d = load_val;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int CNT_W     = 3,
  parameter int RD_CYC    = 4,
  parameter int PULSE_CYC = 3,
  parameter int REC_CYC   = 1,
  parameter int HZ_CYC    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_wr,
  input  logic             zero,
  output seq_state_e       state_q,
  output seq_state_e       state_d,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             accept
);
  localparam logic [CNT_W-1:0] RD_LD    = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LD   = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W-1:0] HZ_LD    = CNT_W'(HZ_CYC - 1);

  logic turn_pend_q, turn_pend_d;

  always_comb begin
    state_d     = state_q;
    load        = 1'b0;
    load_val    = '0;
    accept      = 1'b0;
    turn_pend_d = turn_pend_q;
    case (state_q)
      ST_IDLE: if (req) begin
        accept = 1'b1;
        load   = 1'b1;
        if (!req_wr) begin
          state_d  = ST_READ;
          load_val = RD_LD;
        end else if (turn_pend_q) begin
          state_d  = ST_TURN;
          load_val = HZ_LD;
        end else begin
          state_d  = ST_WPULSE;
          load_val = PULSE_LD;
        end
      end
      ST_READ: if (zero) begin
        state_d     = ST_IDLE;
        turn_pend_d = 1'b1;
      end
      ST_TURN: if (zero) begin
        state_d     = ST_WPULSE;
        load        = 1'b1;
        load_val    = PULSE_LD;
        turn_pend_d = 1'b0;
      end
      ST_WPULSE: if (zero) begin
        state_d  = ST_WREC;
        load     = 1'b1;
        load_val = REC_LD;
      end
      ST_WREC: if (zero) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      turn_pend_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      turn_pend_q <= turn_pend_d;
    end
  end
endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state_d,
  input  logic              accept,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output ram_pins_t         pins_q
);
  logic wdata_en;
  assign wdata_en = accept & req_wr;

  // pins are registered from the next phase so they change glitch-free
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_q <= pins_of(ST_IDLE);
    else        pins_q <= pins_of(state_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mem_addr <= '0;
    else if (accept) mem_addr <= req_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mem_dq_out <= '0;
    else if (wdata_en) mem_dq_out <= req_wdata;
  end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_AA_NS       = 25,
  parameter int T_OE_NS       = 9,
  parameter int T_WP_NS       = 20,
  parameter int T_DW_NS       = 15,
  parameter int T_WR_NS       = 5,
  parameter int T_WC_NS       = 25,
  parameter int T_HZ_NS       = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ncs,
  output logic              mem_ce,
  output logic              mem_nwe,
  output logic              mem_noe,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int RD_CYC    = imax(ns_to_cyc(T_AA_NS, CLK_PERIOD_NS),
                                  ns_to_cyc(T_OE_NS, CLK_PERIOD_NS));
  localparam int PULSE_CYC = imax(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                  ns_to_cyc(T_DW_NS, CLK_PERIOD_NS));
  localparam int REC_CYC   = imax(ns_to_cyc(T_WR_NS, CLK_PERIOD_NS),
                                  ns_to_cyc(T_WC_NS, CLK_PERIOD_NS) - PULSE_CYC);
  localparam int HZ_CYC    = ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS);
  localparam int MAX_CYC   = imax(imax(RD_CYC, PULSE_CYC), imax(REC_CYC, HZ_CYC));
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  seq_state_e       state_q, state_d;
  logic             load, zero, accept;
  logic [CNT_W-1:0] load_val;
  ram_pins_t        pins_q;
  logic             rd_last, wr_last;

  sram_ctl_fsm #(
    .CNT_W(CNT_W), .RD_CYC(RD_CYC), .PULSE_CYC(PULSE_CYC),
    .REC_CYC(REC_CYC), .HZ_CYC(HZ_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .zero(zero),
    .state_q(state_q), .state_d(state_d), .load(load),
    .load_val(load_val), .accept(accept)
  );

  sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .zero(zero)
  );

  sram_ctl_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .state_d(state_d), .accept(accept),
    .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .pins_q(pins_q)
  );

  assign mem_ncs   = pins_q.ncs;
  assign mem_ce    = pins_q.ce;
  assign mem_nwe   = pins_q.nwe;
  assign mem_noe   = pins_q.noe;
  assign mem_dq_oe = pins_q.dq_oe;

  assign rd_last = (state_q == ST_READ) && zero;
  assign wr_last = (state_q == ST_WREC) && zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (rd_last) rdata <= mem_dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= rd_last | wr_last;
  end
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_WP_NS       = 20,
  parameter int T_DW_NS       = 15,
  parameter int T_WR_NS       = 5,
  parameter int T_WC_NS       = 25,
  parameter int T_HZ_NS       = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ncs,
  input logic              mem_ce,
  input logic              mem_nwe,
  input logic              mem_noe,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);
  localparam int PULSE_CYC = imax(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                  ns_to_cyc(T_DW_NS, CLK_PERIOD_NS));
  localparam int REC_CYC   = imax(ns_to_cyc(T_WR_NS, CLK_PERIOD_NS),
                                  ns_to_cyc(T_WC_NS, CLK_PERIOD_NS) - PULSE_CYC);
  localparam int HZ_CYC    = ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS);

  logic [7:0] we_gap_q, oe_gap_q;

  // cycles with the write strobe high since it last was low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              we_gap_q <= 8'hFF;
    else if (!mem_nwe)       we_gap_q <= 8'h00;
    else if (we_gap_q != 8'hFF) we_gap_q <= we_gap_q + 8'h01;
  end

  // cycles with the output gate high since it last was low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              oe_gap_q <= 8'hFF;
    else if (!mem_noe)       oe_gap_q <= 8'h00;
    else if (oe_gap_q != 8'hFF) oe_gap_q <= oe_gap_q + 8'h01;
  end

  // R7
  bus_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_noe);

  // R4
  wr_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_nwe |-> (!mem_ncs && mem_ce && mem_noe));

  // R4
  wr_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_nwe && !$past(mem_nwe)) |-> $stable(mem_addr));

  // R5
  wr_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_nwe && !$past(mem_nwe)) |-> ($stable(mem_dq_out) && mem_dq_oe));

  // R2
  rd_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_noe |-> (!mem_ncs && mem_ce && mem_nwe));

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  wr_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_nwe) |-> (we_gap_q >= 8'(REC_CYC)));

  // R7
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_gap_q >= 8'(HZ_CYC)));

  // R10
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mem_ncs && !mem_ce && mem_nwe && mem_noe && !mem_dq_oe));
endmodule

bind sram_ctl sram_ctl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .T_WP_NS(T_WP_NS), .T_DW_NS(T_DW_NS), .T_WR_NS(T_WR_NS),
  .T_WC_NS(T_WC_NS), .T_HZ_NS(T_HZ_NS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .mem_addr(mem_addr),
  .mem_ncs(mem_ncs), .mem_ce(mem_ce), .mem_nwe(mem_nwe), .mem_noe(mem_noe),
  .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
);

// File: tb/tb_sram_ctl.sv
module tb_sram_ctl;
  localparam int AW = 17;
  localparam int DW = 8;
  localparam int PER = 8;
  localparam int WC_NS = 40;
  // expected phase lengths from the requirement formulas
  localparam int RD  = 4;   // max(ceil(25/8), ceil(9/8))
  localparam int PUL = 3;   // max(ceil(20/8), ceil(15/8))
  localparam int REC = 2;   // max(ceil(5/8), ceil(40/8)-3)
  localparam int HZ  = 2;   // ceil(9/8)

  typedef struct {
    bit         wr;
    bit [AW-1:0] addr;
    bit [DW-1:0] data;
    int         lat;
    int         t0;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_wr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] rdata, mem_dq_out, mem_dq_in;
  logic done, mem_ncs, mem_ce, mem_nwe, mem_noe, mem_dq_oe;
  logic [AW-1:0] mem_addr;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;
  item_t q[$];
  logic [DW-1:0] ref_mem [int];
  logic [DW-1:0] sram [0:255];
  bit last_rd = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sram_ctl #(.CLK_PERIOD_NS(PER), .T_WC_NS(WC_NS)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .rdata(rdata), .done(done), .mem_addr(mem_addr),
    .mem_ncs(mem_ncs), .mem_ce(mem_ce), .mem_nwe(mem_nwe), .mem_noe(mem_noe),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // RAM model: drives only when fully read-enabled
  assign mem_dq_in = (!mem_ncs && mem_ce && !mem_noe && mem_nwe) ? sram[mem_addr[7:0]] : 8'hEE;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ref_rd(input logic [AW-1:0] a);
    if (ref_mem.exists(int'(a))) return ref_mem[int'(a)];
    return a[7:0] ^ 8'h5A;
  endfunction

  task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit spurious);
    item_t it;
    do begin @(negedge clk); #1; end while (q.size() != 0);
    it.wr = wr; it.addr = a; it.t0 = cyc;
    it.data = wr ? d : ref_rd(a);
    it.lat = wr ? (PUL + REC + 1 + (last_rd ? HZ : 0)) : (RD + 1);
    if (wr) ref_mem[int'(a)] = d;
    last_rd = !wr;
    q.push_back(it);
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    @(negedge clk); #1;
    req = 1'b0;
    if (spurious) begin
      // R8: request while busy, must be ignored
      req = 1'b1; req_wr = 1'b1; req_addr = 17'h00077; req_wdata = 8'h99;
      @(negedge clk); #1;
      req = 1'b0;
    end
  endtask

  // monitor / scoreboard and pin timing
  int rd_run = 0, wr_run = 0, we_gap = 1000, oe_gap = 1000;
  bit prev_nwe = 1, prev_noe = 1, prev_oe = 0, any_rd = 0, any_wr = 0;
  logic [AW-1:0] w_addr; logic [DW-1:0] w_data;

  always @(negedge clk) if (rst_n && !finished) begin
    if (done) begin
      if (q.size() == 0) check(0, "R8 unexpected done", 1, 0);
      else begin
        item_t it;
        it = q.pop_front();
        if (it.wr) check(cyc - it.t0 == it.lat, "R6 write latency", cyc - it.t0, it.lat);
        else begin
          check(cyc - it.t0 == it.lat, "R3 read latency", cyc - it.t0, it.lat);
          check(rdata == it.data, "R3 read data", rdata, it.data);
        end
      end
      check(mem_ncs && !mem_ce && mem_nwe && mem_noe && !mem_dq_oe, "R10 idle pins at done",
            {mem_ncs, mem_ce, mem_nwe, mem_noe, mem_dq_oe}, 5'b10110);
    end
    // read window
    if (!mem_noe) begin
      rd_run++;
      any_rd = 1;
      if (q.size() != 0) check(mem_addr == q[0].addr, "R2 read address", mem_addr, q[0].addr);
      check(!mem_ncs && mem_ce && mem_nwe, "R2 read controls", {mem_ncs, mem_ce, mem_nwe}, 3'b011);
    end else if (!prev_noe) begin
      check(rd_run == RD, "R2 read window length", rd_run, RD);
      rd_run = 0;
    end
    // write pulse
    if (!mem_nwe) begin
      if (prev_nwe && any_wr) check(we_gap >= REC, "R6 recovery gap", we_gap, REC);
      wr_run++;
      w_addr = mem_addr; w_data = mem_dq_out;
      check(mem_dq_oe == 1'b1, "R5 drive during pulse", mem_dq_oe, 1);
      if (q.size() != 0) begin
        check(mem_addr == q[0].addr, "R4 write address", mem_addr, q[0].addr);
        check(mem_dq_out == q[0].data, "R5 write data", mem_dq_out, q[0].data);
      end
    end else if (!prev_nwe) begin
      check(wr_run == PUL, "R4 write pulse length", wr_run, PUL);
      check(mem_dq_oe == 1'b0, "R5 release at strobe rise", mem_dq_oe, 0);
      sram[w_addr[7:0]] = w_data;
      wr_run = 0; any_wr = 1;
    end
    // turnaround
    if (mem_dq_oe && !prev_oe && any_rd) check(oe_gap >= HZ, "R7 turnaround", oe_gap, HZ);
    we_gap = mem_nwe ? we_gap + 1 : 0;
    oe_gap = mem_noe ? oe_gap + 1 : 0;
    prev_nwe = mem_nwe; prev_noe = mem_noe; prev_oe = mem_dq_oe;
  end

  initial begin
    for (int i = 0; i < 256; i++) sram[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(mem_ncs && !mem_ce && mem_nwe && mem_noe && !mem_dq_oe && !done, "R1 reset pins",
          {mem_ncs, mem_ce, mem_nwe, mem_noe, mem_dq_oe, done}, 6'b101100);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(mem_ncs && !mem_ce && mem_nwe && mem_noe && !mem_dq_oe && !done, "R1 idle after reset",
          {mem_ncs, mem_ce, mem_nwe, mem_noe, mem_dq_oe, done}, 6'b101100);
    do_op(1, 17'h00000, 8'h3C, 0);
    do_op(1, 17'h1FFFF, 8'hC3, 0);       // R9 back-to-back writes
    do_op(0, 17'h00000, 8'h00, 0);
    do_op(0, 17'h1FFFF, 8'h00, 0);       // R9 back-to-back reads
    do_op(1, 17'h00123, 8'hFF, 0);       // R7 write after read
    do_op(0, 17'h00123, 8'h00, 0);
    do_op(0, 17'h00042, 8'h00, 0);       // unwritten location
    do_op(1, 17'h0ABCD, 8'h00, 1);       // R8 spurious write while busy
    do_op(0, 17'h00077, 8'h00, 0);       // R8 location must be untouched
    do_op(0, 17'h0ABCD, 8'h00, 1);
    for (int i = 0; i < 8; i++) begin
      do_op(1, 17'(32'h100 * i + 32'h10 + i), 8'(8'h21 * i + 8'h07), i[0]);
      if (i[1]) do_op(0, 17'(32'h100 * i + 32'h10 + i), 8'h00, 0);
    end
    for (int i = 0; i < 8; i++) do_op(0, 17'(32'h100 * i + 32'h10 + i), 8'h00, 0);
    do begin @(negedge clk); #1; end while (q.size() != 0);
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule